// File: doc/BRIEF.md
# ADC Sample Capture with Alternating Section Buffers

This block drives a parallel-output analog-to-digital converter and delivers every conversion result to two consumers. The first consumer is the device under test. It receives each sample at the full conversion rate, either over a short memory queue with a valid/ready handshake or over a direct bypass that skips the queue latency. The second consumer is a slow host. It reads whole sections of samples from one of two equal capture banks while the other bank fills.

A rate divider sets the conversion period and issues one start pulse per period. The converter raises a busy line while it converts. The data word is latched on the clock edge where busy is first seen low again. Once a section of programmed length has been written, the write bank swaps and a sticky section-ready flag comes up. The host read port always addresses the bank completed most recently. The host clears the flag with an acknowledge. A section that completes while the previous one is still unacknowledged raises an overrun flag, and the older section is overwritten.

Back-pressure rules for the device-under-test stream: in queued mode a word moves on each cycle where `dut_valid` and `dut_ready` are both high, and words stay in order. A sample that arrives while the queue is full is discarded. In bypass mode `dut_ready` is ignored and every sample is shown for exactly one cycle.

Top module: `adc_section_capture`

## Requirements
- R1: While `run` is high, `adc_start` pulses for one cycle every `rate_div`+1 cycles. While `run` is low, no pulse is issued.
- R2: The sample is the value on `adc_data` in the cycle where `adc_busy` is first seen low after being high.
- R3: With `bypass_en` high, each sample appears on `dut_data` with `dut_valid` high for exactly one cycle, in arrival order, whatever `dut_ready` does.
- R4: With `bypass_en` low, samples pass through a FIFO_DEPTH-entry queue in order under valid/ready. A sample that arrives while the queue holds FIFO_DEPTH entries is discarded.
- R5: A section holds `sec_len_m1`+1 consecutive samples. The n-th sample of a section (counting from 0) is stored at host address n. After reset, the first section begins with the first sample.
- R6: When a section completes, `sect_valid` goes high and the host port switches to that section. The host port keeps returning it unchanged while the next section fills.
- R7: A cycle with `host_ack` high and no section completing clears both `sect_valid` and `overrun` on the next cycle.
- R8: If a section completes while `sect_valid` is still high and `host_ack` is low, `overrun` goes high and the host port then returns the newest section.
- R9: `host_rdata` shows the word at `host_addr` one cycle after the address is applied.
- R10: After reset, `adc_start`, `dut_valid`, `sect_valid` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables conversion starts |
| rate_div | input | DIV_W | Conversion period minus one, in cycles |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_busy | input | 1 | Converter busy; its fall marks new data |
| adc_data | input | SMP_W | Parallel converter data |
| bypass_en | input | 1 | 1: direct path, 0: queued path |
| dut_valid | output | 1 | Sample valid towards the device under test |
| dut_ready | input | 1 | Device under test accepts (queued mode only) |
| dut_data | output | SMP_W | Sample towards the device under test |
| sec_len_m1 | input | AW | Section length minus one |
| host_addr | input | AW | Host read address inside the ready section |
| host_rdata | output | SMP_W | Host read data, one cycle latency |
| host_ack | input | 1 | Host acknowledge of the ready section |
| sect_valid | output | 1 | Sticky: a completed section is readable |
| overrun | output | 1 | Sticky: an unread section was overwritten |

## Verification
The bench builds the block with 16-word capture banks and a 4-entry queue. This keeps the maximum section length and a full queue within a few hundred cycles, so the bench reaches the longest section, one-sample sections, queue overflow with discards, and back-to-back unacknowledged sections in one short run. Conversion periods and section lengths are drawn at random around these limits, and ready is toggled at random in queued mode.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_LO) ? BANK_HI : BANK_LO;
  endfunction
endpackage

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int SMP_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] rate_div,
  output logic             adc_start,
  input  logic             adc_busy,
  input  logic [SMP_W-1:0] adc_data,
  output logic             smp_vld,
  output logic [SMP_W-1:0] smp_data
);
  logic [DIV_W-1:0] tick_cnt;
  logic             busy_q;
  logic             busy_fall;

  assign busy_fall = busy_q && !adc_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt  <= '0;
      adc_start <= 1'b0;
      busy_q    <= 1'b0;
      smp_vld   <= 1'b0;
      smp_data  <= '0;
    end else begin
      adc_start <= run && (tick_cnt == '0);
      if (!run)                tick_cnt <= '0;
      else if (tick_cnt == '0) tick_cnt <= rate_div;
      else                     tick_cnt <= tick_cnt - 1'b1;
      busy_q  <= adc_busy;
      smp_vld <= busy_fall;
      if (busy_fall) smp_data <= adc_data;
    end
  end

  // R1: no start while idle; starts are separated when the period exceeds one cycle
  p_no_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !adc_start);
  p_start_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && run && rate_div != '0) |=> !adc_start);
  // R2: one captured sample per busy fall, never two in a row
  p_single_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld);
endmodule

// File: rtl/adc_dut_fifo.sv
module adc_dut_fifo #(
  parameter int SMP_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SMP_W-1:0] push_data,
  input  logic             pop,
  output logic             q_valid,
  output logic [SMP_W-1:0] q_data
);
  localparam int FAW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW  = FAW + 1;

  logic [SMP_W-1:0] slot [FIFO_DEPTH];
  logic [FAW-1:0]   wr_p, rd_p;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  assign q_valid = (fill != '0);
  assign q_data  = slot[rd_p];
  assign do_push = push && (fill != CW'(FIFO_DEPTH));
  assign do_pop  = pop && q_valid;

  always_ff @(posedge clk) begin
    if (do_push) slot[wr_p] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      fill <= '0;
    end else begin
      if (do_push) wr_p <= (wr_p == FAW'(FIFO_DEPTH-1)) ? '0 : wr_p + 1'b1;
      if (do_pop)  rd_p <= (rd_p == FAW'(FIFO_DEPTH-1)) ? '0 : rd_p + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R4: occupancy never passes the queue depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(FIFO_DEPTH));
  // R4: a full queue with no pop keeps its occupancy when a sample arrives
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(FIFO_DEPTH) && !pop) |=> fill == CW'(FIFO_DEPTH));
endmodule

// File: rtl/adc_sect_buf.sv
module adc_sect_buf
  import adc_cap_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter int BUF_DEPTH = 64,
  parameter int AW        = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [AW-1:0]    sec_len_m1,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_ack,
  output logic [SMP_W-1:0] host_rdata,
  output logic             sect_valid,
  output logic             overrun
);
  bank_e            wr_bank, rd_bank;
  logic [AW-1:0]    wptr;
  logic             sect_done;
  logic [SMP_W-1:0] bank_word [2];

  assign sect_done = smp_vld && (wptr == sec_len_m1);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [SMP_W-1:0] mem [BUF_DEPTH];
    always_ff @(posedge clk) begin
      if (smp_vld && wr_bank == bank_e'(g)) mem[wptr] <= smp_data;
    end
    assign bank_word[g] = mem[host_addr];
  end

  always_ff @(posedge clk) begin
    host_rdata <= (rd_bank == BANK_HI) ? bank_word[1] : bank_word[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      wr_bank    <= BANK_LO;
      rd_bank    <= BANK_HI;
      sect_valid <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (sect_done) begin
        wptr    <= '0;
        rd_bank <= wr_bank;
        wr_bank <= other_bank(wr_bank);
      end else if (smp_vld) begin
        wptr <= wptr + 1'b1;
      end
      if (sect_done)     sect_valid <= 1'b1;
      else if (host_ack) sect_valid <= 1'b0;
      if (sect_done && sect_valid && !host_ack) overrun <= 1'b1;
      else if (host_ack)                        overrun <= 1'b0;
    end
  end

  // R6: the ready flag only rises at a section boundary
  p_valid_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sect_valid) |-> (wptr == '0));
  // R7: an acknowledge with no completion clears the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !sect_done) |=> (!sect_valid && !overrun));
  // R8: overrun only follows an unacknowledged ready section
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(sect_valid) && !$past(host_ack)));
endmodule

// File: rtl/adc_section_capture.sv
module adc_section_capture #(
  parameter int SMP_W      = 16,
  parameter int DIV_W      = 16,
  parameter int BUF_DEPTH  = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int AW         = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] rate_div,
  output logic             adc_start,
  input  logic             adc_busy,
  input  logic [SMP_W-1:0] adc_data,
  input  logic             bypass_en,
  output logic             dut_valid,
  input  logic             dut_ready,
  output logic [SMP_W-1:0] dut_data,
  input  logic [AW-1:0]    sec_len_m1,
  input  logic [AW-1:0]    host_addr,
  output logic [SMP_W-1:0] host_rdata,
  input  logic             host_ack,
  output logic             sect_valid,
  output logic             overrun
);
  logic             smp_vld;
  logic [SMP_W-1:0] smp_data;
  logic             q_valid;
  logic [SMP_W-1:0] q_data;

  adc_conv_ctrl #(.SMP_W(SMP_W), .DIV_W(DIV_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .run(run), .rate_div(rate_div),
    .adc_start(adc_start), .adc_busy(adc_busy), .adc_data(adc_data),
    .smp_vld(smp_vld), .smp_data(smp_data)
  );

  adc_dut_fifo #(.SMP_W(SMP_W), .FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(smp_vld && !bypass_en), .push_data(smp_data),
    .pop(!bypass_en && dut_ready),
    .q_valid(q_valid), .q_data(q_data)
  );

  adc_sect_buf #(.SMP_W(SMP_W), .BUF_DEPTH(BUF_DEPTH), .AW(AW)) u_sect (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .sec_len_m1(sec_len_m1), .host_addr(host_addr), .host_ack(host_ack),
    .host_rdata(host_rdata), .sect_valid(sect_valid), .overrun(overrun)
  );

  assign dut_valid = bypass_en ? smp_vld  : q_valid;
  assign dut_data  = bypass_en ? smp_data : q_data;

  // R3: in bypass mode a sample is shown for a single cycle
  p_bypass_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && dut_valid && $stable(bypass_en)) |=> !(bypass_en && dut_valid));
  // R4: a queued word stays put until it is taken
  p_hold_until_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_en && dut_valid && !dut_ready) |=> (bypass_en || (dut_valid && $stable(dut_data))));
endmodule

// File: tb/adc_section_capture_bench.sv
module adc_section_capture_bench;
  localparam int SW = 16, DW = 16, BD = 16, FD = 4, AW = 4;

  logic          clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [DW-1:0] rate_div = 16'd5;
  logic          adc_start, adc_busy = 1'b0;
  logic [SW-1:0] adc_data = '0;
  logic          bypass_en = 1'b1, dut_valid, dut_ready = 1'b0;
  logic [SW-1:0] dut_data, host_rdata;
  logic [AW-1:0] sec_len_m1 = '0, host_addr = '0;
  logic          host_ack = 1'b0, sect_valid, overrun;

  int checks = 0, bad = 0, epoch = 0, issued = 0, rx_k = 0, rx_mode = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_section_capture #(.SMP_W(SW), .DIV_W(DW), .BUF_DEPTH(BD), .FIFO_DEPTH(FD), .AW(AW))
    u_adc_section_capture (
    .clk(clk), .rst_n(rst_n), .run(run), .rate_div(rate_div), .adc_start(adc_start),
    .adc_busy(adc_busy), .adc_data(adc_data), .bypass_en(bypass_en), .dut_valid(dut_valid),
    .dut_ready(dut_ready), .dut_data(dut_data), .sec_len_m1(sec_len_m1),
    .host_addr(host_addr), .host_rdata(host_rdata), .host_ack(host_ack),
    .sect_valid(sect_valid), .overrun(overrun));

  function automatic logic [15:0] sval(int e, int k);
    return 16'((k * 40503 + e * 7919 + 4660) & 32'hFFFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: busy for three cycles after each start
  initial begin
    int bcnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        adc_busy = 1'b0; issued = 0; bcnt = 0;
      end else if (adc_start) begin
        adc_busy = 1'b1; bcnt = 3;
      end else if (adc_busy) begin
        bcnt--;
        if (bcnt == 0) begin
          adc_data = sval(epoch, issued);
          issued++;
          adc_busy = 1'b0;
        end
      end
    end
  end

  // stream sink: R3 (bypass) and R4 (queued) ordering
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) rx_k = 0;
      else begin
        case (rx_mode)
          0: dut_ready = 1'b0;
          1: dut_ready = 1'($urandom_range(0, 1));
          default: dut_ready = 1'b1;
        endcase
        if (dut_valid && (bypass_en || dut_ready)) begin
          chk(bypass_en ? "R3 bypass order" : "R4 queue order", dut_data, sval(epoch, rx_k));
          rx_k++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); run = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0; epoch++; host_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(string req);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (sect_valid) break;
    end
    chk(req, sect_valid, 1'b1);
  endtask

  task automatic read_sect(int first, int len, string req);
    for (int i = 0; i < len; i++) begin
      host_addr = AW'(i);
      @(negedge clk);
      chk(req, host_rdata, sval(epoch, first + i));
    end
  endtask

  task automatic ack_pulse();
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  task automatic period_chk(int exp);
    int n = 0;
    for (int i = 0; i < 200 && !adc_start; i++) @(negedge clk);
    do begin @(negedge clk); n++; end while (!adc_start && n < 200);
    chk("R1 start period", n, exp);
  endtask

  initial begin
    int len, n;
    void'($urandom(32'h5A17));
    do_reset();
    chk("R10 start low", adc_start, 0);
    chk("R10 dut_valid low", dut_valid, 0);
    chk("R10 sect_valid low", sect_valid, 0);
    chk("R10 overrun low", overrun, 0);
    n = 0;
    repeat (100) begin @(negedge clk); if (adc_start) n++; end
    chk("R1 idle no start", n, 0);

    // directed: longest section, bypass with ready held low (R2 R3 R5 R6 R9)
    rate_div = DW'($urandom_range(5, 12)); sec_len_m1 = AW'(BD - 1);
    bypass_en = 1'b1; rx_mode = 0; run = 1'b1;
    period_chk(int'(rate_div) + 1);
    period_chk(int'(rate_div) + 1);
    wait_valid("R6 ready after section");
    read_sect(0, BD, "R5 R2 R6 R9 section 0 stable while next fills");
    chk("R8 no overrun", overrun, 0);
    ack_pulse();
    chk("R7 ack clears ready", sect_valid, 0);
    wait_valid("R6 second section");
    read_sect(BD, BD, "R5 R6 section 1");
    chk("R3 bypass samples seen", rx_k > 0, 1);

    // random: queued path, random ready, no acknowledge (R4 R8 R7)
    do_reset();
    rate_div = DW'($urandom_range(5, 12)); len = $urandom_range(3, 16);
    sec_len_m1 = AW'(len - 1); bypass_en = 1'b0; rx_mode = 1; run = 1'b1;
    wait_valid("R6 queued section 0");
    for (int i = 0; i < 6000 && !overrun; i++) @(negedge clk);
    chk("R8 overrun set", overrun, 1);
    read_sect(len, len, "R8 newest section readable");
    run = 1'b0;
    repeat (60) @(negedge clk);
    chk("R4 no loss under random ready", rx_k, issued);
    ack_pulse();
    chk("R7 ack clears ready", sect_valid, 0);
    chk("R7 ack clears overrun", overrun, 0);

    // directed: queue full with ready low, excess discarded (R4)
    do_reset();
    rate_div = 16'd5; sec_len_m1 = AW'(BD - 1); bypass_en = 1'b0; rx_mode = 0; run = 1'b1;
    for (int i = 0; i < 2000 && issued < FD + 4; i++) @(negedge clk);
    run = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 held while not ready", dut_valid, 1);
    chk("R4 nothing taken", rx_k, 0);
    rx_mode = 2;
    repeat (20) @(negedge clk);
    chk("R4 only queue depth delivered", rx_k, FD);
    chk("R4 queue empty", dut_valid, 0);

    // directed: one-sample sections (R5 R8)
    do_reset();
    rate_div = 16'd5; sec_len_m1 = '0; bypass_en = 1'b1; rx_mode = 1; run = 1'b1;
    wait_valid("R6 single-sample section");
    repeat (20) @(negedge clk);
    run = 1'b0;
    repeat (30) @(negedge clk);
    n = issued;
    chk("R8 overrun on repeated sections", overrun, (n >= 2) ? 1 : 0);
    read_sect(n - 1, 1, "R5 length-one newest sample");
    ack_pulse();
    chk("R7 ack clears", {sect_valid, overrun}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule